// File: doc/BRIEF.md
# Wormhole Mesh Router Tile

This block is one switching node of a two-dimensional grid of processing tiles. It has five ports (four toward the neighbouring tiles and one toward the local processor), and each port carries a 32-bit word stream in each direction with valid/ready handshakes. A packet is a header word followed by a number of payload words. The header word gives that count. The router steers each packet toward its destination tile and forwards it as a continuous worm. It never drops a word. When a downstream port stalls, words pile up in the small input queues, and then the upstream sender sees its ready drop.

Every input has a FIFO. The word at the head of an idle input is read as a header. Its destination coordinates are compared with the tile's own coordinates, which are parameters. The x direction is resolved before the y direction, and a packet addressed to this tile leaves on the local port. A free output takes one input through a rotating-priority arbiter. It then belongs to that input until the header and all payload words counted from the header have passed. After that it is released for the next allocation.

Port index mapping on every vector: 0 local processor, 1 north (toward larger y), 2 south (toward smaller y), 3 east (toward larger x), 4 west (toward smaller x). Port k uses bits [32k+31:32k] of the data vectors.

Top module: `mesh_router`

## Requirements
- R1: While reset is held and in the cycle after it is released, every output valid is low and every input ready is high.
- R2: A header word carries the destination x in bits [3:0], the destination y in bits [7:4] and the payload length in bits [15:8], from 0 to 128. Bits [31:16] pass through unchanged. A packet is the header plus exactly that many payload words, and a header-only packet (length 0) is legal.
- R3: A packet whose destination x is greater than the tile's x leaves on port 3 (east). A packet whose destination x is smaller leaves on port 4 (west). The y coordinate is not considered until x matches.
- R4: With x matching, a larger destination y goes to port 1 (north) and a smaller one to port 2 (south). When both coordinates match, the packet goes to port 0 (local).
- R5: Each packet appears on its output as one unbroken run of words, header first, with payload words in their original order. No word of another packet enters the run, and packets from one input to one output keep their order.
- R6: When several inputs hold headers for the same free output, grants rotate among them, so two inputs that keep competing are served alternately.
- R7: An input FIFO holds FIFO_DEPTH words and drops its ready once full. A stalled output loses no word, and all words are delivered once the output accepts again.
- R8: While an output's valid is high and its ready is low, the valid stays high and the data stays unchanged in the next cycle.
- R9: A packet with the maximum payload of 128 words passes through intact, with all 129 words delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 5 | Word offered on each input port |
| in_ready | output | 5 | Input FIFO of each port can take a word |
| in_data | input | 160 | Five 32-bit input words, port k at bits [32k+31:32k] |
| out_valid | output | 5 | Word offered on each output port |
| out_ready | input | 5 | Downstream of each output port accepts the word |
| out_data | output | 160 | Five 32-bit output words, port k at bits [32k+31:32k] |

## Verification
The checks on output routing and header length assume that every packet entering an input really contains the number of payload words its header announces, and that no announced length is above 128. Without that, the router and the checker lose track of where headers sit in the stream. The bench never writes words to an input directly. It builds every packet with one task that writes the header and exactly the stated number of payload words, and it draws lengths only from 0 to 12 or exactly 128. Input valid may be dropped and raised again at random while a word is waiting. The router does not depend on valid being held steady, so the checks do not assume it either.

// File: rtl/mesh_rtr_pkg.sv
package mesh_rtr_pkg;

    localparam int NPORT   = 5;
    localparam int WORD_W  = 32;
    localparam int CRD_W   = 4;
    localparam int LEN_W   = 8;
    localparam int MAX_LEN = 128;
    localparam int PIDX_W  = $clog2(NPORT);
    localparam int CNT_W   = LEN_W + 1;

    typedef enum logic [PIDX_W-1:0] {
        P_LOCAL = 3'd0,
        P_NORTH = 3'd1,
        P_SOUTH = 3'd2,
        P_EAST  = 3'd3,
        P_WEST  = 3'd4
    } port_e;

    // first field is the most significant
    typedef struct packed {
        logic [WORD_W-LEN_W-2*CRD_W-1:0] tag;
        logic [LEN_W-1:0]                len;
        logic [CRD_W-1:0]                dy;
        logic [CRD_W-1:0]                dx;
    } hdr_t;

    // x dimension settled before y
    function automatic port_e route_dir(hdr_t h, logic [CRD_W-1:0] hx, logic [CRD_W-1:0] hy);
        if (h.dx > hx)      return P_EAST;
        else if (h.dx < hx) return P_WEST;
        else if (h.dy > hy) return P_NORTH;
        else if (h.dy < hy) return P_SOUTH;
        return P_LOCAL;
    endfunction

    function automatic logic [PIDX_W-1:0] onehot_idx(logic [NPORT-1:0] v);
        logic [PIDX_W-1:0] r;
        r = '0;
        for (int k = 0; k < NPORT; k++) begin
            if (v[k]) r = PIDX_W'(k);
        end
        return r;
    endfunction

endpackage

// File: rtl/mesh_rtr_fifo.sv
module mesh_rtr_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         not_empty,
    output logic         not_full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;

    function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) wp <= bump(wp);
            if (pop)  rp <= bump(rp);
            cnt <= cnt + CW'(push) - CW'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wp] <= wdata;
    end

    assign rdata     = mem[rp];
    assign not_empty = (cnt != '0);
    assign not_full  = (cnt != CW'(DEPTH));

endmodule

// File: rtl/mesh_rtr_rr_arb.sv
module mesh_rtr_rr_arb #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    logic [IW-1:0] last_q, win;

    // search starts one past the previous winner
    always_comb begin
        gnt = '0;
        win = last_q;
        for (int k = 1; k <= N; k++) begin
            int idx;
            idx = (int'(last_q) + k) % N;
            if (gnt == '0 && req[idx]) begin
                gnt[idx] = 1'b1;
                win      = IW'(idx);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)       last_q <= IW'(N - 1);
        else if (|req) last_q <= win;
    end

endmodule

// File: rtl/mesh_router.sv
module mesh_router
    import mesh_rtr_pkg::*;
#(
    parameter int MY_X       = 3,
    parameter int MY_Y       = 4,
    parameter int FIFO_DEPTH = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NPORT-1:0]        in_valid,
    output logic [NPORT-1:0]        in_ready,
    input  logic [NPORT*WORD_W-1:0] in_data,
    output logic [NPORT-1:0]        out_valid,
    input  logic [NPORT-1:0]        out_ready,
    output logic [NPORT*WORD_W-1:0] out_data
);
    localparam logic [CRD_W-1:0] HX = CRD_W'(MY_X);
    localparam logic [CRD_W-1:0] HY = CRD_W'(MY_Y);

    logic [NPORT-1:0]  f_ne, f_nf, f_pop, in_lock;
    logic [NPORT-1:0]  o_busy, o_fire;
    logic [WORD_W-1:0] f_head  [NPORT];
    port_e             in_dir  [NPORT];
    logic [PIDX_W-1:0] o_owner [NPORT];

    // input side: queue, route decode of the head, lock and pop
    for (genvar i = 0; i < NPORT; i++) begin : g_in
        logic lock_i, pop_i;

        mesh_rtr_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) fifo_i (
            .clk       (clk),
            .rst       (rst),
            .push      (in_valid[i] & f_nf[i]),
            .wdata     (in_data[i*WORD_W +: WORD_W]),
            .pop       (f_pop[i]),
            .rdata     (f_head[i]),
            .not_empty (f_ne[i]),
            .not_full  (f_nf[i])
        );

        assign in_ready[i] = f_nf[i];
        assign in_dir[i]   = route_dir(hdr_t'(f_head[i]), HX, HY);

        always_comb begin
            lock_i = 1'b0;
            pop_i  = 1'b0;
            for (int o = 0; o < NPORT; o++) begin
                if (o_busy[o] && o_owner[o] == PIDX_W'(i)) begin
                    lock_i = 1'b1;
                    pop_i  = o_fire[o];
                end
            end
        end

        assign in_lock[i] = lock_i;
        assign f_pop[i]   = pop_i;
    end

    // output side: allocation, word counting, data steering
    for (genvar o = 0; o < NPORT; o++) begin : g_out
        logic [NPORT-1:0]  req, gnt;
        logic [PIDX_W-1:0] gidx, owner_q;
        logic [CNT_W-1:0]  left_q;
        logic              busy_q;
        hdr_t              g_hdr;

        always_comb begin
            for (int i = 0; i < NPORT; i++) begin
                req[i] = f_ne[i] && !in_lock[i] && !busy_q &&
                         (in_dir[i] == port_e'(PIDX_W'(o)));
            end
        end

        mesh_rtr_rr_arb #(.N(NPORT)) arb_i (
            .clk (clk),
            .rst (rst),
            .req (req),
            .gnt (gnt)
        );

        assign gidx  = onehot_idx(gnt);
        assign g_hdr = hdr_t'(f_head[gidx]);

        always_ff @(posedge clk) begin
            if (rst) begin
                busy_q  <= 1'b0;
                owner_q <= '0;
                left_q  <= '0;
            end else if (busy_q) begin
                if (o_fire[o]) begin
                    left_q <= left_q - 1'b1;
                    if (left_q == CNT_W'(1)) busy_q <= 1'b0;
                end
            end else if (|gnt) begin
                busy_q  <= 1'b1;
                owner_q <= gidx;
                left_q  <= CNT_W'(g_hdr.len) + CNT_W'(1);
            end
        end

        assign o_busy[o]                    = busy_q;
        assign o_owner[o]                   = owner_q;
        assign out_valid[o]                 = busy_q && f_ne[owner_q];
        assign o_fire[o]                    = out_valid[o] && out_ready[o];
        assign out_data[o*WORD_W +: WORD_W] = f_head[owner_q];
    end

endmodule

// File: rtl/mesh_router_chk.sv
module mesh_router_chk
    import mesh_rtr_pkg::*;
#(
    parameter int MY_X       = 3,
    parameter int MY_Y       = 4,
    parameter int FIFO_DEPTH = 4
) (
    input logic                    clk,
    input logic                    rst,
    input logic [NPORT-1:0]        in_valid,
    input logic [NPORT-1:0]        in_ready,
    input logic [NPORT*WORD_W-1:0] in_data,
    input logic [NPORT-1:0]        out_valid,
    input logic [NPORT-1:0]        out_ready,
    input logic [NPORT*WORD_W-1:0] out_data
);
    localparam logic [CRD_W-1:0] HX = CRD_W'(MY_X);
    localparam logic [CRD_W-1:0] HY = CRD_W'(MY_Y);

    AST_IDLE_RESET: assert property (@(posedge clk) disable iff (rst) $past(rst) |-> (out_valid == '0)); // R1
    AST_READY_RESET: assert property (@(posedge clk) disable iff (rst) $past(rst) |-> (&in_ready)); // R1

    for (genvar o = 0; o < NPORT; o++) begin : g_chk
        logic [LEN_W:0] c_left;
        hdr_t           oh;

        assign oh = hdr_t'(out_data[o*WORD_W +: WORD_W]);

        // tracks header position on this output from the observed stream
        always_ff @(posedge clk) begin
            if (rst) c_left <= '0;
            else if (out_valid[o] && out_ready[o])
                c_left <= (c_left == '0) ? {1'b0, oh.len} : c_left - 1'b1;
        end

        AST_ROUTE_DIR: assert property (@(posedge clk) disable iff (rst) (out_valid[o] && c_left == '0) |-> (route_dir(oh, HX, HY) == port_e'(PIDX_W'(o)))); // R3
        AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (rst) (out_valid[o] && c_left == '0) |-> (int'(oh.len) <= MAX_LEN)); // R2
        AST_HOLD_VALID: assert property (@(posedge clk) disable iff (rst) (out_valid[o] && !out_ready[o]) |=> out_valid[o]); // R8
        AST_HOLD_DATA: assert property (@(posedge clk) disable iff (rst) (out_valid[o] && !out_ready[o]) |=> $stable(out_data[o*WORD_W +: WORD_W])); // R8
    end

endmodule

bind mesh_router mesh_router_chk #(.MY_X(MY_X), .MY_Y(MY_Y), .FIFO_DEPTH(FIFO_DEPTH)) chk_i (.*);

// File: tb/mesh_router_tb_top.sv
module mesh_router_tb_top;

    localparam int NP    = 5;
    localparam int W     = 32;
    localparam int MX    = 3;
    localparam int MY    = 4;
    localparam int DEPTH = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NP-1:0]   in_valid, in_ready, out_valid, out_ready;
    logic [NP*W-1:0] in_data, out_data;

    always #4 clk = ~clk;

    mesh_router #(.MY_X(MX), .MY_Y(MY), .FIFO_DEPTH(DEPTH)) dut_i (.*);

    int nchk = 0, nerr = 0;
    logic [31:0] in_q [NP][$];
    logic [31:0] exp_hdr [NP][NP][$];
    logic [31:0] cur_hdr [NP];
    int mleft [NP];
    int pidx [NP];
    int acc_cnt [NP];
    int tot_exp = 0, tot_rcv = 0, max_done = 0, seq = 0;
    bit gap_mode = 0, rand_rdy = 0, rec_ord = 0, done_flag = 0;
    logic [NP-1:0] hold_rdy = '0;
    int ord_q [$];

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // expected output port: 0 local, 1 north, 2 south, 3 east, 4 west
    function automatic int exp_dir(input logic [3:0] dx, input logic [3:0] dy);
        if (dx > 4'(MX)) return 3;
        if (dx < 4'(MX)) return 4;
        if (dy > 4'(MY)) return 1;
        if (dy < 4'(MY)) return 2;
        return 0;
    endfunction

    function automatic logic [31:0] pay(input logic [31:0] h, input int k);
        return {h[31:16], h[7:0], 8'(k)};
    endfunction

    task automatic add_pkt(input int src, input int dx, input int dy, input int len,
                           output logic [31:0] h);
        h = {3'(src), 13'(seq), 8'(len), 4'(dy), 4'(dx)};
        seq++;
        in_q[src].push_back(h);
        for (int k = 0; k < len; k++) in_q[src].push_back(pay(h, k));
        exp_hdr[exp_dir(4'(dx), 4'(dy))][src].push_back(h);
        tot_exp += len + 1;
    endtask

    task automatic mon(input int o, input logic [31:0] w);
        if (mleft[o] == 0) begin
            int src;
            bit ok;
            int ed;
            src = int'(w[31:29]);
            ed  = exp_dir(w[3:0], w[7:4]);
            chk(ed == o, (w[3:0] == 4'(MX)) ? "R4" : "R3", o, ed);
            ok = 0;
            if (src < NP) begin
                if (exp_hdr[o][src].size() > 0) begin
                    if (exp_hdr[o][src][0] == w) begin
                        ok = 1;
                        void'(exp_hdr[o][src].pop_front());
                    end
                end
            end
            chk(ok, "R5", w, 0);
            cur_hdr[o] = w;
            mleft[o]   = int'(w[15:8]);
            pidx[o]    = 0;
            if (rec_ord && o == 0) ord_q.push_back(src);
        end else begin
            chk(w == pay(cur_hdr[o], pidx[o]), "R5", w, pay(cur_hdr[o], pidx[o]));
            pidx[o]++;
            mleft[o]--;
            if (mleft[o] == 0 && cur_hdr[o][15:8] == 8'd128) max_done++;
        end
        tot_rcv++;
    endtask

    task automatic step();
        @(negedge clk);
        for (int i = 0; i < NP; i++) begin
            if (in_q[i].size() > 0 && (!gap_mode || ($urandom % 4) != 0)) begin
                in_valid[i]       = 1'b1;
                in_data[i*W +: W] = in_q[i][0];
            end else begin
                in_valid[i] = 1'b0;
            end
        end
        for (int o = 0; o < NP; o++) begin
            if (hold_rdy[o])   out_ready[o] = 1'b0;
            else if (rand_rdy) out_ready[o] = (($urandom % 3) != 0);
            else               out_ready[o] = 1'b1;
        end
        #1;
        for (int i = 0; i < NP; i++) begin
            if (in_valid[i] && in_ready[i]) begin
                void'(in_q[i].pop_front());
                acc_cnt[i]++;
            end
        end
        for (int o = 0; o < NP; o++) begin
            if (out_valid[o] && out_ready[o]) mon(o, out_data[o*W +: W]);
        end
    endtask

    function automatic bit pending();
        for (int i = 0; i < NP; i++) begin
            if (in_q[i].size() > 0 || mleft[i] != 0) return 1;
            for (int j = 0; j < NP; j++) if (exp_hdr[i][j].size() > 0) return 1;
        end
        return 0;
    endfunction

    task automatic drain(input string req);
        int n = 0;
        while (pending() && n < 40000) begin
            step();
            n++;
        end
        chk(!pending(), req, n, 0);
        chk(tot_rcv == tot_exp, req, tot_rcv, tot_exp);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done_flag) begin
            nerr++;
            $display("FAIL watchdog actual=%0d expected=%0d", tot_rcv, tot_exp);
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end

    initial begin
        logic [31:0] h;
        int a0;
        void'($urandom(32'd1777));
        in_valid  = '0;
        in_data   = '0;
        out_ready = '0;
        for (int i = 0; i < NP; i++) begin
            mleft[i]   = 0;
            pidx[i]    = 0;
            acc_cnt[i] = 0;
            cur_hdr[i] = '0;
        end
        repeat (5) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk(out_valid == '0, "R1", out_valid, 0);
        chk(in_ready == 5'h1f, "R1", in_ready, 5'h1f);

        // R3 R4 R2: every direction from the local input, header-only packet included
        add_pkt(0, 5, 4, 2, h);
        add_pkt(0, 0, 4, 2, h);
        add_pkt(0, 3, 7, 2, h);
        add_pkt(0, 3, 1, 2, h);
        add_pkt(0, 3, 4, 0, h);
        add_pkt(0, 5, 0, 3, h);
        add_pkt(0, 1, 9, 1, h);
        add_pkt(3, 3, 4, 2, h);
        add_pkt(1, 3, 2, 1, h);
        drain("R2");

        // R6: two inputs contend for a stalled local output
        ord_q.delete();
        rec_ord     = 1;
        hold_rdy[0] = 1'b1;
        for (int k = 0; k < 3; k++) begin
            add_pkt(1, 3, 4, 3, h);
            add_pkt(4, 3, 4, 3, h);
        end
        repeat (10) step();
        hold_rdy[0] = 1'b0;
        drain("R6");
        chk(ord_q.size() == 6, "R6", ord_q.size(), 6);
        for (int k = 1; k < ord_q.size(); k++) chk(ord_q[k] != ord_q[k-1], "R6", ord_q[k], ord_q[k-1]);
        rec_ord = 0;

        // R7 R8: backpressure fills the east input queue
        hold_rdy[0] = 1'b1;
        a0 = acc_cnt[3];
        add_pkt(3, 3, 4, 10, h);
        repeat (20) step();
        chk(acc_cnt[3] - a0 == DEPTH, "R7", acc_cnt[3] - a0, DEPTH);
        chk(in_ready[3] == 1'b0, "R7", in_ready[3], 0);
        for (int k = 0; k < 8; k++) begin
            step();
            chk(out_valid[0] && out_data[31:0] == h, "R8", out_data[31:0], h);
        end
        hold_rdy[0] = 1'b0;
        drain("R7");

        // R9: maximum length packet sharing the east output with a short one
        rand_rdy = 1;
        add_pkt(2, 7, 4, 128, h);
        add_pkt(0, 6, 2, 5, h);
        add_pkt(1, 3, 4, 4, h);
        drain("R9");
        chk(max_done == 1, "R9", max_done, 1);

        // R5 R3 R4: random traffic with gaps and random readiness
        gap_mode = 1;
        for (int n = 0; n < 300; n++) begin
            int len;
            len = (($urandom % 40) == 0) ? 128 : int'($urandom % 13);
            add_pkt(int'($urandom % NP), int'($urandom % 8), int'($urandom % 8), len, h);
        end
        drain("R5");
        chk(max_done >= 1, "R9", max_done, 1);

        done_flag = 1;
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

endmodule